// File: doc/BRIEF.md
# BCD Watchdog Timer and Interrupt Router

This block combines a watchdog whose reload value is held as four BCD digits with the control logic that decides what reaches a single interrupt pin. The reload value sits in two byte registers. The low byte holds tenths and hundredths of a second, and the high byte holds tens of seconds and seconds. Together they span 00.01 s to 99.99 s. The countdown advances on a 100 Hz tick supplied from outside. When the countdown expires it raises a watchdog flag, reloads itself and starts again, so the alarm repeats until software services it. Software services the watchdog by reading or writing either reload register. Either access restarts the count and clears the flag. A reload value of all zeros disables the watchdog.

A command register chooses one interrupt source: the watchdog, or a time-of-day alarm event that arrives from a separate comparator. It also selects level or pulse output and holds a separate mask for each source. In level mode a flag stays set until its source is serviced. In pulse mode the flag, and the interrupt with it, lasts a parameterised number of ticks and then drops by itself. The register bus is a plain single-cycle select/write-enable interface. Read data is combinational and has no back-pressure, so no valid/ready handshake is used.

Top module: `wdt_irq_ctrl`

## Requirements
- R1: After reset every register reads 0x00. The reload bytes at 0x0C (low) and 0x0D (high) read back exactly what was written. The command register at 0x0B reads its written bits 7..2, with the watchdog flag in bit 1 and the time-of-day flag in bit 0; writes to bits 1..0 are ignored.
- R2: A read or a write of 0x0C or 0x0D clears the watchdog flag on the following cycle and restarts the countdown from the reload value held after that access.
- R3: With a nonzero reload, the watchdog flag sets on the N-th tick after the last reload access. N is the four-digit BCD value {0x0D high nibble, 0x0D low nibble, 0x0C high nibble, 0x0C low nibble} read as thousands, hundreds, tens and units.
- R4: When no access follows an expiry, the countdown reloads and fires again every N ticks.
- R5: When both reload bytes are zero, the watchdog flag never sets.
- R6: Command bit 6 routes the interrupt: 1 selects the watchdog flag and 0 selects the time-of-day flag. The source that is not selected never drives irq.
- R7: With command bit 4 set (pulse mode), a flag and the interrupt it drives stay high for PULSE_TICKS ticks after they set and then clear without any access. Flag bits 1 and 0 read 1 only during that window.
- R8: Command bit 3 set masks the watchdog interrupt, and bit 2 set masks the time-of-day interrupt. A masked flag still sets and reads back, and irq stays low.
- R9: A tod_event pulse sets the time-of-day flag. In level mode the flag and irq stay high until a tod_ack pulse clears them.
- R10: The countdown borrows correctly across BCD digit boundaries, from 00.01 s up to 99.99 s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 100 Hz time base pulse |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for 0x0B..0x0D, combinational, 0 elsewhere |
| tod_event | input | 1 | Time-of-day alarm match pulse |
| tod_ack | input | 1 | Time-of-day alarm registers were accessed |
| irq | output | 1 | Interrupt, active high |
| wd_flag | output | 1 | Watchdog flag |

## Verification
The countdown is driven with a set of reload values chosen to separate the failure modes. Single-digit values check the units digit. Values of 10, 99 and 100 ticks make a carry cross one digit boundary and then two. 123 mixes the digits, and 99.99 s exercises all four digits at their widest. Each value is checked one tick before the expected expiry as well as at it, so an off-by-one in the period is caught. Directed sequences then separate the cases that share an output: a read as opposed to a write servicing the watchdog, expiry under level as against pulse mode, repeat after auto-reload, a masked flag that still reads back, and a time-of-day event that arrives while the watchdog is routed, or the reverse.

// File: rtl/wdt_irq_pkg.sv
package wdt_irq_pkg;
  localparam int unsigned DIGIT_W   = 4;
  // command register bit positions (software decodes these)
  localparam int unsigned CMD_ROUTE = 6;
  localparam int unsigned CMD_PULSE = 4;
  localparam int unsigned CMD_WMASK = 3;
  localparam int unsigned CMD_TMASK = 2;
  localparam int unsigned CMD_WFLAG = 1;
  localparam int unsigned CMD_TFLAG = 0;

  typedef struct packed {
    logic [DIGIT_W-1:0] val;
    logic               borrow;
  } digit_dec_t;

  function automatic digit_dec_t dec_digit(input logic [DIGIT_W-1:0] d, input logic bin);
    digit_dec_t r;
    if (!bin) begin
      r.val = d;
      r.borrow = 1'b0;
    end else if (d == '0) begin
      r.val = DIGIT_W'(9);
      r.borrow = 1'b1;
    end else begin
      r.val = d - 1'b1;
      r.borrow = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/wd_bcd_counter.sv
module wd_bcd_counter
  import wdt_irq_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [DIGITS*DIGIT_W-1:0] load_val,
  input  logic                      dec,
  output logic                      at_one
);
  localparam int unsigned W = DIGITS * DIGIT_W;

  logic [W-1:0]    cnt_q;
  logic [W-1:0]    cnt_dec;
  logic [DIGITS:0] borrow;

  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    digit_dec_t r;
    assign r = dec_digit(cnt_q[g*DIGIT_W +: DIGIT_W], borrow[g]);
    assign cnt_dec[g*DIGIT_W +: DIGIT_W] = r.val;
    assign borrow[g+1] = r.borrow;
  end

  assign at_one = (cnt_q == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_dec;
  end
endmodule

// File: rtl/irq_src_flag.sv
module irq_src_flag #(
  parameter int unsigned PULSE_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic tick,
  input  logic pulse_mode,
  output logic flag
);
  localparam int unsigned CW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      cnt_q <= '0;
    end else if (clr) begin
      flag  <= 1'b0;
      cnt_q <= '0;
    end else if (set) begin
      flag  <= 1'b1;
      cnt_q <= '0;
    end else if (flag && pulse_mode && tick) begin
      if (cnt_q == LAST) flag <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_irq_ctrl.sv
module wdt_irq_ctrl
  import wdt_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_CMD    = 'h0B,
  parameter int unsigned ADDR_LO     = 'h0C,
  parameter int unsigned ADDR_HI     = 'h0D,
  parameter int unsigned PULSE_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tod_event,
  input  logic              tod_ack,
  output logic              irq,
  output logic              wd_flag
);
  localparam int unsigned RELOAD_W = 2 * DATA_W;
  localparam int unsigned DIGITS   = RELOAD_W / DIGIT_W;

  logic [DATA_W-1:0]   lo_q, hi_q, lo_nx, hi_nx;
  logic [DATA_W-1:2]   cmd_q;
  logic [RELOAD_W-1:0] reload_q, reload_nx;
  logic hit_cmd, hit_lo, hit_hi, wd_access;
  logic wd_enabled, at_one, fire, cnt_load, cnt_dec;
  logic tod_flag;

  assign hit_cmd   = bus_sel && (bus_addr == ADDR_W'(ADDR_CMD));
  assign hit_lo    = bus_sel && (bus_addr == ADDR_W'(ADDR_LO));
  assign hit_hi    = bus_sel && (bus_addr == ADDR_W'(ADDR_HI));
  assign wd_access = hit_lo || hit_hi;

  assign lo_nx     = (hit_lo && bus_we) ? bus_wdata : lo_q;
  assign hi_nx     = (hit_hi && bus_we) ? bus_wdata : hi_q;
  assign reload_q  = {hi_q, lo_q};
  assign reload_nx = {hi_nx, lo_nx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      cmd_q <= '0;
    end else begin
      lo_q <= lo_nx;
      hi_q <= hi_nx;
      if (hit_cmd && bus_we) cmd_q <= bus_wdata[DATA_W-1:2];
    end
  end

  assign wd_enabled = (reload_q != '0);
  assign fire       = tick && wd_enabled && !wd_access && at_one;
  assign cnt_load   = wd_access || fire;
  assign cnt_dec    = tick && wd_enabled && !wd_access && !at_one;

  wd_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (wd_access ? reload_nx : reload_q),
    .dec      (cnt_dec),
    .at_one   (at_one)
  );

  irq_src_flag #(.PULSE_TICKS(PULSE_TICKS)) u_wd_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .set        (fire),
    .clr        (wd_access),
    .tick       (tick),
    .pulse_mode (cmd_q[CMD_PULSE]),
    .flag       (wd_flag)
  );

  irq_src_flag #(.PULSE_TICKS(PULSE_TICKS)) u_tod_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .set        (tod_event),
    .clr        (tod_ack),
    .tick       (tick),
    .pulse_mode (cmd_q[CMD_PULSE]),
    .flag       (tod_flag)
  );

  assign irq = cmd_q[CMD_ROUTE] ? (wd_flag && !cmd_q[CMD_WMASK])
                                : (tod_flag && !cmd_q[CMD_TMASK]);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (hit_cmd) begin
        bus_rdata[DATA_W-1:2] = cmd_q;
        bus_rdata[CMD_WFLAG]  = wd_flag;
        bus_rdata[CMD_TFLAG]  = tod_flag;
      end else if (hit_lo) begin
        bus_rdata = lo_q;
      end else if (hit_hi) begin
        bus_rdata = hi_q;
      end
    end
  end
endmodule

// File: rtl/wdt_irq_ctrl_chk.sv
module wdt_irq_ctrl_chk #(
  parameter int unsigned RELOAD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                wd_access,
  input logic [RELOAD_W-1:0] reload_q,
  input logic                wd_flag,
  input logic                tod_flag,
  input logic                route_wd,
  input logic                pulse_mode,
  input logic                irq
);
  p_access_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wd_access |=> !wd_flag);

  p_flag_sets_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag) |-> $past(tick));

  p_zero_disables_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q == '0 && !wd_flag) |=> !wd_flag);

  p_route_wd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && route_wd) |-> wd_flag);

  p_route_tod_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !route_wd) |-> tod_flag);

  p_pulse_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && $fell(wd_flag)) |-> ($past(tick) || $past(wd_access)));
endmodule

bind wdt_irq_ctrl wdt_irq_ctrl_chk #(.RELOAD_W(RELOAD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .wd_access  (wd_access),
  .reload_q   (reload_q),
  .wd_flag    (wd_flag),
  .tod_flag   (tod_flag),
  .route_wd   (cmd_q[6]),
  .pulse_mode (cmd_q[4]),
  .irq        (irq)
);

// File: tb/wdt_irq_ctrl_tb.sv
module wdt_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic tod_event = 1'b0, tod_ack = 1'b0;
  logic irq, wd_flag;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  wdt_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tod_event(tod_event), .tod_ack(tod_ack), .irq(irq), .wd_flag(wd_flag)
  );

  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{16'h0001, 16'h0005, 16'h0010, 16'h0099,
                                       16'h0100, 16'h0123, 16'h1001, 16'h9999};

  function automatic int bcd2int(input logic [15:0] v);
    return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk);
      tick = 0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic pulse_tod(input bit ack);
    if (ack) tod_ack = 1; else tod_event = 1;
    @(negedge clk);
    tod_ack = 0; tod_event = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(6'h0B, d); check("R1 reset cmd", d, 8'h00);
    rd(6'h0C, d); check("R1 reset lo", d, 8'h00);
    rd(6'h0D, d); check("R1 reset hi", d, 8'h00);
    check("R1 reset irq", irq, 0);
    check("R1 reset flag", wd_flag, 0);

    // R3 R10 table walk, level mode routed to watchdog
    wr(6'h0B, 8'h40);
    for (int v = 0; v < NV; v++) begin
      int n;
      n = bcd2int(VEC[v]);
      wr(6'h0C, VEC[v][7:0]);
      wr(6'h0D, VEC[v][15:8]);
      ticks(n - 1);
      check("R3 R10 before expiry", {wd_flag, irq}, 2'b00);
      ticks(1);
      check("R3 R10 at expiry", {wd_flag, irq}, 2'b11);
    end

    // R1 readback
    wr(6'h0C, 8'h34); wr(6'h0D, 8'h12);
    rd(6'h0C, d); check("R1 lo readback", d, 8'h34);
    rd(6'h0D, d); check("R1 hi readback", d, 8'h12);
    wr(6'h0B, 8'hFF);
    rd(6'h0B, d); check("R1 cmd readback flags ignored", d, 8'hFC);

    // R2 read services the watchdog
    wr(6'h0B, 8'h40);
    wr(6'h0C, 8'h05); wr(6'h0D, 8'h00);
    ticks(3);
    rd(6'h0C, d);
    ticks(4);
    check("R2 read restarts count", wd_flag, 0);
    ticks(1);
    check("R2 expiry after restart", wd_flag, 1);
    rd(6'h0D, d);
    check("R2 read clears flag", {wd_flag, irq}, 2'b00);

    // R7 R4 pulse mode and auto-repeat
    wr(6'h0B, 8'h50);
    wr(6'h0C, 8'h03);
    ticks(3);
    check("R7 pulse high", {wd_flag, irq}, 2'b11);
    rd(6'h0B, d); check("R7 flag bit during pulse", d[1], 1);
    ticks(1);
    check("R7 pulse ends", {wd_flag, irq}, 2'b00);
    rd(6'h0B, d); check("R7 flag bit after pulse", d[1], 0);
    ticks(1);
    check("R4 no early repeat", wd_flag, 0);
    ticks(1);
    check("R4 auto repeat", {wd_flag, irq}, 2'b11);

    // R5 zero disables
    wr(6'h0B, 8'h40);
    wr(6'h0C, 8'h00); wr(6'h0D, 8'h00);
    ticks(20);
    check("R5 zero reload never fires", {wd_flag, irq}, 2'b00);

    // R8 watchdog mask
    wr(6'h0B, 8'h48);
    wr(6'h0C, 8'h02);
    ticks(2);
    check("R8 masked wd flag sets, irq low", {wd_flag, irq}, 2'b10);
    wr(6'h0B, 8'h40);
    check("R8 unmask shows irq", irq, 1);

    // R6 route to time-of-day; watchdog flag still set
    wr(6'h0B, 8'h00);
    check("R6 wd flag not routed", {wd_flag, irq}, 2'b10);
    pulse_tod(0);
    check("R9 tod sets irq", irq, 1);
    ticks(3);
    rd(6'h0B, d); check("R9 level holds tod flag", {d[0], irq}, 2'b11);
    pulse_tod(1);
    check("R9 ack clears", irq, 0);
    rd(6'h0B, d); check("R9 tod flag cleared", d[0], 0);

    // R6 tod flag not seen when routed to watchdog
    rd(6'h0C, d);
    wr(6'h0B, 8'h40);
    pulse_tod(0);
    check("R6 tod not routed", irq, 0);
    pulse_tod(1);

    // R8 tod mask
    wr(6'h0B, 8'h04);
    pulse_tod(0);
    rd(6'h0B, d); check("R8 masked tod flag reads, irq low", {d[0], irq}, 2'b10);
    pulse_tod(1);

    // R7 tod pulse mode
    wr(6'h0C, 8'h00);
    wr(6'h0B, 8'h10);
    pulse_tod(0);
    check("R7 tod pulse high", irq, 1);
    ticks(1);
    rd(6'h0B, d); check("R7 tod pulse ends", {d[0], irq}, 2'b00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule